// File: doc/BRIEF.md
# Dual DAC stream start controller

This block sits between the sample sources and two dual-channel DAC serializer engines. It decides, frame by frame, whether each engine is sending samples and which source feeds it. Between them the two engines drive four output channels. An engine takes its samples from a DMA stream, from the ADC capture path looped back, or from an internal ramp counter. Software writes a command to each engine: stop, free-running start, or synchronized start. In synchronized start, an engine that has been armed stays silent until its partner is armed too, and then both begin on the same clock edge.

All timing is built from a common slot counter. A frame has two slots. The first channel of each engine gets its valid pulse in the first slot and the second channel gets its pulse one slot later. Commands take effect only at frame boundaries. While an engine is commanded to stream or is still streaming, its output-range field is locked. A write to the field is dropped, and a read of it returns an error flag.

Top module: `dual_dac_start_ctrl`

## Requirements
- R1: After reset, both engines hold the stop command with source code 0 (DMA), both range fields read the default code 4, the status register reads 0 and all sample-valid outputs are low.
- R2: Address 0 (engine 0) and address 1 (engine 1) are control registers with the source in bits [1:0] and the command in bits [5:4]. Command codes are 0 stop, 1 start, 2 synchronized start. A written command code 3 is stored as stop. Reads return the same bit layout.
- R3: A start command begins streaming at the next frame boundary. While streaming, each channel of the engine gets exactly one valid pulse per frame.
- R4: An engine in synchronized start emits nothing while its partner is not armed. When both are armed, both begin streaming at the same clock edge, so both first-channel valids rise in the same cycle.
- R5: The pair is released whichever engine is armed first, and either stop order is accepted. If one engine is started free-running or stopped while the other waits armed, the waiting engine stays held until its partner is armed for synchronized start.
- R6: Address 2 (engine 0) and address 3 (engine 1) hold a 3-bit range field in bits [2:0]. A write to the field is ignored while that engine is commanded to start or is still streaming. A read in that state returns data 0 with the error flag set. The other engine's field is unaffected.
- R7: Within an engine, the second channel's valid pulse comes exactly one slot after the first channel's, and never in the same cycle. Channel 0 of engine e is smp_vld[2e], with data on smp_data[32e+15:32e]. Channel 1 is smp_vld[2e+1], with data on smp_data[32e+31:32e+16].
- R8: Source code 0 selects the engine's DMA input and code 1 its ADC-loopback input. Bits [15:0] of a source input feed channel 0 and bits [31:16] feed channel 1. The source is sampled at each frame boundary.
- R9: Source code 2 selects the ramp, which feeds the same value to both channels. It starts at 0 on the first frame after a start, increases by one each frame, and wraps from 0xFFFF to 0x0000.
- R10: A stop command ends streaming at the next frame boundary and clears any pending synchronized arm of that engine. Address 4 is the status register: 2 bits per engine (engine 0 in [1:0], engine 1 in [3:2]), reading 0 for idle, 1 for armed-waiting and 2 for streaming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| reg_err | output | 1 | Read error flag for locked range fields |
| dma_in0 | input | 32 | Engine 0 DMA samples {ch1, ch0} |
| dma_in1 | input | 32 | Engine 1 DMA samples {ch1, ch0} |
| adc_in0 | input | 32 | Engine 0 ADC-loopback samples {ch1, ch0} |
| adc_in1 | input | 32 | Engine 1 ADC-loopback samples {ch1, ch0} |
| smp_vld | output | 4 | Per-channel sample valid toward the serializers |
| smp_data | output | 64 | Per-channel 16-bit samples |

## Verification
Two things can land on the same clock edge: a synchronized release that starts both engines, and a register write that changes an engine's command. The bench arms one engine and then arms the partner. It also starts the partner free-running, or stops and re-arms engines in both orders, and it checks whether the two first-channel valids rise together or stay low. The other case is a range write that meets a command change. It is provoked by writing the range field while the engine is streaming and again once it has stopped, and it is judged by reading back the field and the error flag.

// File: rtl/dual_dac_start_ctrl.sv
module dual_dac_start_ctrl #(
  parameter int DW        = 16,
  parameter int RW        = 3,
  parameter int RANGE_DEF = 4,
  parameter int SLOT_CYC  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [2:0]     reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  output logic           reg_err,
  input  logic [2*DW-1:0] dma_in0,
  input  logic [2*DW-1:0] dma_in1,
  input  logic [2*DW-1:0] adc_in0,
  input  logic [2*DW-1:0] adc_in1,
  output logic [3:0]     smp_vld,
  output logic [4*DW-1:0] smp_data
);
  localparam int CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [1:0] C_STOP = 2'd0, C_RUN = 2'd1, C_SYNC = 2'd2;
  localparam logic [1:0] S_ADC = 2'd1, S_RAMP = 2'd2;

  logic [CW-1:0]   cnt;
  logic            phase;
  logic [1:0]      cmd  [2];
  logic [1:0]      src  [2];
  logic [RW-1:0]   rng  [2];
  logic [DW-1:0]   ramp [2];
  logic [2*DW-1:0] hold [2];
  logic [2*DW-1:0] pick [2];
  logic [1:0]      run, busy, armed, run_nx, st [2];

  wire slot_end  = (cnt == CW'(SLOT_CYC - 1));
  wire frame_end = slot_end & phase;
  wire slot_head = (cnt == '0);
  wire pair_go   = &armed;

  always_comb begin
    for (int e = 0; e < 2; e++) begin
      busy[e]  = (cmd[e] != C_STOP) | run[e];
      armed[e] = (cmd[e] == C_SYNC) & ~run[e];
      case (cmd[e])
        C_RUN:   run_nx[e] = 1'b1;
        C_SYNC:  run_nx[e] = run[e] | pair_go;
        default: run_nx[e] = 1'b0;
      endcase
      st[e] = run[e] ? 2'd2 : (cmd[e] == C_SYNC ? 2'd1 : 2'd0);
    end
  end

  always_comb begin
    pick[0] = dma_in0;
    pick[1] = dma_in1;
    if (src[0] == S_ADC)  pick[0] = adc_in0;
    if (src[1] == S_ADC)  pick[1] = adc_in1;
    if (src[0] == S_RAMP) pick[0] = {ramp[0], ramp[0]};
    if (src[1] == S_RAMP) pick[1] = {ramp[1], ramp[1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
      run   <= '0;
      for (int e = 0; e < 2; e++) begin
        cmd[e]  <= C_STOP;
        src[e]  <= 2'd0;
        rng[e]  <= RW'(RANGE_DEF);
        ramp[e] <= '0;
        hold[e] <= '0;
      end
    end else begin
      cnt <= slot_end ? '0 : cnt + 1'b1;
      if (slot_end) phase <= ~phase;
      for (int e = 0; e < 2; e++) begin
        if (reg_wr && reg_addr == 3'(e)) begin
          src[e] <= reg_wdata[1:0];
          cmd[e] <= (reg_wdata[5:4] == 2'd3) ? C_STOP : reg_wdata[5:4];
        end
        if (reg_wr && reg_addr == 3'(e + 2) && !busy[e])
          rng[e] <= reg_wdata[RW-1:0];
        if (frame_end) begin
          run[e] <= run_nx[e];
          if (run_nx[e]) begin
            hold[e] <= pick[e];
            ramp[e] <= ramp[e] + 1'b1;
          end else begin
            ramp[e] <= '0;
          end
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    reg_err   = 1'b0;
    if (reg_rd) begin
      case (reg_addr)
        3'd0:    reg_rdata = {2'b00, cmd[0], 2'b00, src[0]};
        3'd1:    reg_rdata = {2'b00, cmd[1], 2'b00, src[1]};
        3'd2:    if (busy[0]) reg_err = 1'b1; else reg_rdata = 8'(rng[0]);
        3'd3:    if (busy[1]) reg_err = 1'b1; else reg_rdata = 8'(rng[1]);
        3'd4:    reg_rdata = {4'b0000, st[1], st[0]};
        default: reg_rdata = '0;
      endcase
    end
  end

  for (genvar e = 0; e < 2; e++) begin : g_out
    assign smp_vld[2*e]   = run[e] & slot_head & ~phase;
    assign smp_vld[2*e+1] = run[e] & slot_head & phase;
    assign smp_data[2*DW*e +: 2*DW] = hold[e];
  end
endmodule

// File: rtl/dual_dac_start_ctrl_sva.sv
module dual_dac_start_ctrl_sva #(
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    smp_vld,
  input logic [1:0]    run,
  input logic [1:0]    busy,
  input logic [1:0]    cmd0,
  input logic [1:0]    cmd1,
  input logic [RW-1:0] rng0,
  input logic [RW-1:0] rng1
);
  AST_SLOT_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_vld[0] && smp_vld[1]) && !(smp_vld[2] && smp_vld[3])); // R7
  AST_PAIR_RELEASE_A: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run[0]) && $past(cmd0) == 2'd2) |-> $rose(run[1])); // R4
  AST_PAIR_RELEASE_B: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run[1]) && $past(cmd1) == 2'd2) |-> $rose(run[0])); // R4
  AST_RANGE_LOCK_A: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy[0]) |-> $stable(rng0)); // R6
  AST_RANGE_LOCK_B: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy[1]) |-> $stable(rng1)); // R6
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd0 != 2'd3 && cmd1 != 2'd3); // R2
  AST_VLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(smp_vld) <= 2); // R3
endmodule

bind dual_dac_start_ctrl dual_dac_start_ctrl_sva #(.RW(RW)) u_sva (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .run(run), .busy(busy),
  .cmd0(cmd[0]), .cmd1(cmd[1]), .rng0(rng[0]), .rng1(rng[1])
);

// File: tb/tb_dual_dac_start_ctrl.sv
module tb_dual_dac_start_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 195000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        reg_err;
  logic [31:0] dma_in0 = 32'hBBBB_AAAA, dma_in1 = 32'hDDDD_CCCC;
  logic [31:0] adc_in0 = 32'h2222_1111, adc_in1 = 32'h4444_3333;
  logic [3:0]  smp_vld;
  logic [63:0] smp_data;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_start_ctrl #(.SLOT_CYC(1)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_err(reg_err), .dma_in0(dma_in0), .dma_in1(dma_in1),
    .adc_in0(adc_in0), .adc_in1(adc_in1), .smp_vld(smp_vld), .smp_data(smp_data));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input bit experr, input string tag);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1;
    chk(reg_rdata == exp && reg_err == experr, tag, {reg_err, reg_rdata}, {experr, exp});
    reg_rd = 1'b0;
  endtask

  task automatic wait_vld(input int ch, input string tag);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (smp_vld[ch]) return;
    end
    chk(1'b0, tag, 0, 1);
  endtask

  task automatic quiet(input int n, input logic [3:0] mask, input string tag);
    logic [3:0] seen = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      seen |= smp_vld & mask;
    end
    chk(seen == 4'b0, tag, seen, 0);
  endtask

  task automatic first_pair(input logic [3:0] exp, input string tag);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (smp_vld != 4'b0) break;
    end
    chk(smp_vld == exp, tag, smp_vld, exp);
  endtask

  // {is_write, addr[2:0], wdata[7:0], exp_rdata[7:0], exp_err}
  localparam int NV = 14;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 3'd2, 8'h00, 8'h04, 1'b0},  // R1 range0 default
    {1'b0, 3'd3, 8'h00, 8'h04, 1'b0},  // R1 range1 default
    {1'b0, 3'd0, 8'h00, 8'h00, 1'b0},  // R1 ctrl0 stop/DMA
    {1'b0, 3'd4, 8'h00, 8'h00, 1'b0},  // R1 status idle
    {1'b1, 3'd2, 8'h03, 8'h00, 1'b0},
    {1'b0, 3'd2, 8'h00, 8'h03, 1'b0},  // R6 write accepted when stopped
    {1'b1, 3'd0, 8'h32, 8'h00, 1'b0},
    {1'b0, 3'd0, 8'h00, 8'h02, 1'b0},  // R2 code 3 stored as stop
    {1'b1, 3'd0, 8'h11, 8'h00, 1'b0},
    {1'b0, 3'd0, 8'h00, 8'h11, 1'b0},  // R2 start/ADC readback
    {1'b1, 3'd2, 8'h06, 8'h00, 1'b0},
    {1'b0, 3'd2, 8'h00, 8'h00, 1'b1},  // R6 busy read error
    {1'b0, 3'd3, 8'h00, 8'h04, 1'b0},  // R6 other engine unaffected
    {1'b1, 3'd0, 8'h01, 8'h00, 1'b0}
  };

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(smp_vld == 4'b0, "R1 valids low in reset", smp_vld, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) wr(VEC[i][19:17], VEC[i][16:9]);
      else rd(VEC[i][19:17], VEC[i][8:1], VEC[i][0], $sformatf("R1/R2/R6 vector %0d", i));
    end
    repeat (4) @(negedge clk);
    rd(3'd2, 8'h03, 1'b0, "R6 rejected write left field unchanged");
    rd(3'd4, 8'h00, 1'b0, "R10 status idle after stop");

    // DMA streaming, slot order
    wr(3'd0, 8'h10);
    wait_vld(0, "R3 start streams");
    chk(smp_data[15:0] == 16'hAAAA, "R8 DMA ch0", smp_data[15:0], 16'hAAAA);
    chk(smp_vld[1] == 1'b0, "R7 ch1 not with ch0", smp_vld[1], 0);
    @(negedge clk);
    chk(smp_vld[1:0] == 2'b10, "R7 ch1 one slot later", smp_vld[1:0], 2'b10);
    chk(smp_data[31:16] == 16'hBBBB, "R8 DMA ch1", smp_data[31:16], 16'hBBBB);
    rd(3'd4, 8'h02, 1'b0, "R10 status streaming");
    wr(3'd0, 8'h11);
    repeat (4) @(negedge clk);
    wait_vld(0, "R8 ADC stream");
    chk(smp_data[31:0] == 32'h2222_1111, "R8 ADC source", smp_data[31:0], 32'h2222_1111);
    wr(3'd0, 8'h00);
    repeat (3) @(negedge clk);
    quiet(10, 4'b1111, "R10 stop ends stream");

    // synchronized start, engine 1 first
    wr(3'd1, 8'h20);
    quiet(20, 4'b1111, "R4 armed engine held alone");
    rd(3'd4, 8'h04, 1'b0, "R10 status armed-waiting");
    wr(3'd0, 8'h20);
    first_pair(4'b0101, "R4 pair released same edge");
    chk(smp_data[47:32] == 16'hCCCC, "R8 engine1 DMA ch0", smp_data[47:32], 16'hCCCC);
    rd(3'd4, 8'h0A, 1'b0, "R10 both streaming");
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    repeat (3) @(negedge clk);
    quiet(10, 4'b1111, "R5 stop second then first");

    // partner free-running while one waits
    wr(3'd1, 8'h20);
    wr(3'd0, 8'h10);
    wait_vld(0, "R5 free-run partner streams");
    quiet(20, 4'b1100, "R5 waiting engine stays held");
    wr(3'd0, 8'h00);
    repeat (3) @(negedge clk);
    wr(3'd0, 8'h20);
    first_pair(4'b0101, "R5 re-arm releases pair");
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    repeat (3) @(negedge clk);

    // stop clears arm
    wr(3'd1, 8'h20);
    wr(3'd1, 8'h00);
    rd(3'd4, 8'h00, 1'b0, "R10 stop clears arm status");
    wr(3'd0, 8'h20);
    quiet(20, 4'b1111, "R10 cleared arm does not release");
    wr(3'd1, 8'h20);
    first_pair(4'b0101, "R4 arm order engine0 first");
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    repeat (3) @(negedge clk);

    // ramp and wrap
    wr(3'd0, 8'h12);
    wait_vld(0, "R9 ramp start");
    chk(smp_data[31:0] == 32'h0, "R9 ramp first value", smp_data[31:0], 0);
    wait_vld(0, "R9 ramp step");
    chk(smp_data[15:0] == 16'h0001, "R9 ramp increments", smp_data[15:0], 1);
    for (int i = 2; i < 65535; i++) wait_vld(0, "R9 ramp run");
    wait_vld(0, "R9 ramp top");
    chk(smp_data[15:0] == 16'hFFFF, "R9 ramp top value", smp_data[15:0], 16'hFFFF);
    wait_vld(0, "R9 ramp wrap");
    chk(smp_data[31:0] == 32'h0, "R9 ramp wraps to zero", smp_data[31:0], 0);
    wr(3'd0, 8'h02);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule